// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Staged Configuration

This block paces row refreshes for an embedded DRAM. A down-counter runs on the core clock. Each time it expires, the block raises a refresh request toward the command sequencer. The interval is a number of core clock cycles, so software has to pick it for the clock frequency in use. When one setting must cover a range of frequencies, software computes it for the lowest frequency in that range. A full refresh pass covers 1024 rows spread evenly across the pass. Three junction-temperature grades need different pass lengths:

- grade 0: about 16.4 ms per pass, roughly 16 µs per row;
- grade 1: about 8.2 ms per pass, roughly 8 µs per row;
- grade 2: about 4.1 ms per pass, roughly 4 µs per row.

The block therefore holds one interval register per grade. A grade input picks which one is used.

Software writes new intervals into a staging copy. It first sets a busy flag, then writes the intervals, then clears the flag. The running timer keeps its old settings until the flag falls. At that moment the staged values become active and the counter restarts. Requests are held until acknowledged, and missed intervals are counted so none are lost. The block tracks the row address itself and advances it on each accepted acknowledge.

Two small state machines do the work.

The timer has three states:
- LOAD: the single cycle after reset.
- COUNT: counting down.
- OFF: the selected interval is zero.

Every LOAD and every OFF cycle performs a reload. COUNT also reloads on expiry or on a configuration apply, and otherwise decrements. A reload goes to COUNT when the selected interval is nonzero and to OFF when it is zero.

The request machine has two states:
- QUIET: nothing owed. It moves to ASK on an expiry.
- ASK: one or more refreshes owed. It returns to QUIET when the last owed refresh is acknowledged.

Top module: `rfsh_sched`

## Requirements
- R1: With a nonzero selected interval P and the acknowledge held high, the row address advances exactly K times in any window of K·P consecutive cycles, i.e. one refresh per P core clock cycles.
- R2: Grade code 0, 1 and 2 on `temp_grade` selects the interval for grade 0, 1 and 2; code 3 uses the grade 2 interval.
- R3: The grade is sampled only when the counter reloads; a grade change during a running interval leaves that interval's length unchanged and takes effect from the next one.
- R4: Write address 0 bit 0 is the busy flag; addresses 1, 2, 3 hold the staged intervals for grades 0, 1, 2; interval writes change only the staged copy.
- R5: Writing 0 to the busy flag while it is 1 copies all staged intervals to the active set and reloads the counter from the new value in that same cycle. While the flag is 1 the old intervals stay in force. Writing 0 while the flag is already 0 changes nothing.
- R6: `rfsh_req` is high exactly while `rfsh_pending` is nonzero. Each expiry without an accepted acknowledge raises `rfsh_pending` by one, up to a ceiling of 4. Each accepted acknowledge without an expiry lowers it by one.
- R7: Each acknowledge accepted while `rfsh_req` is high advances `rfsh_row` by one, wrapping from 1023 to 0.
- R8: An acknowledge while `rfsh_req` is low has no effect on `rfsh_row` or `rfsh_pending`.
- R9: When the selected interval is zero, no refresh requests are issued and `cfg_err` is high. As soon as a nonzero interval is selected, counting resumes and `cfg_err` falls.
- R10: After reset, `rfsh_req`, `rfsh_pending`, `rfsh_row` and `cfg_err` are 0 and the busy flag is clear. Both interval sets hold the parameter defaults: 3200, 1600 and 800 cycles, i.e. 16, 8 and 4 µs at 200 MHz. The counter loads in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | CNT_W | Configuration write data |
| temp_grade | input | 2 | Junction-temperature grade code |
| rfsh_req | output | 1 | Refresh request toward the command sequencer |
| rfsh_ack | input | 1 | Refresh acknowledge from the command sequencer |
| rfsh_row | output | ROW_W | Row to refresh next |
| rfsh_pending | output | PEND_W | Number of refreshes owed |
| cfg_err | output | 1 | Selected interval is zero; refresh generation halted |

## Verification
The assertions assume that every input carries a known value once reset has been released. They also allow the acknowledge and the grade to change in any cycle, because the design has to tolerate an acknowledge arriving with no request, and a grade change in the middle of an interval. The bench drives all inputs to defined values from time zero and changes them only between clock edges. It sweeps every grade code over small intervals, so every expected count follows directly from the interval arithmetic. It issues configuration writes one per cycle, so a flag write and an interval write never coincide.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int unsigned NUM_GRADES = 3;
    localparam int unsigned ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd0;

    typedef enum logic [1:0] {
        TM_LOAD  = 2'd0,
        TM_COUNT = 2'd1,
        TM_OFF   = 2'd2
    } tmr_state_e;

    typedef enum logic {
        RQ_QUIET = 1'b0,
        RQ_ASK   = 1'b1
    } req_state_e;

endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs
    import rfsh_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEF_P0 = 3200,
    parameter int unsigned DEF_P1 = 1600,
    parameter int unsigned DEF_P2 = 800
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [CNT_W-1:0]                      wdata,
    output logic                                  apply,
    output logic [NUM_GRADES-1:0][CNT_W-1:0]      eff_period
);

    logic                             busy_q;
    logic [NUM_GRADES-1:0][CNT_W-1:0] stage_q;
    logic [NUM_GRADES-1:0][CNT_W-1:0] active_q;

    // Falling edge of the busy flag, taken from the write itself
    assign apply = wr_en && (addr == ADDR_FLAG) && !wdata[0] && busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (wr_en && (addr == ADDR_FLAG)) begin
            busy_q <= wdata[0];
        end
    end

    for (genvar g = 0; g < NUM_GRADES; g++) begin : g_grade
        localparam logic [CNT_W-1:0] DFLT =
            (g == 0) ? CNT_W'(DEF_P0) : (g == 1) ? CNT_W'(DEF_P1) : CNT_W'(DEF_P2);
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g + 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g]  <= DFLT;
                active_q[g] <= DFLT;
            end else begin
                if (wr_en && (addr == MY_ADDR)) begin
                    stage_q[g] <= wdata;
                end
                if (apply) begin
                    active_q[g] <= stage_q[g];
                end
            end
        end

        // The timer sees the new value in the very cycle of the apply
        assign eff_period[g] = apply ? stage_q[g] : active_q[g];
    end

    // R5: active set moves only on an apply, and then to the staged copy
    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(active_q));
    p_apply_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (active_q == $past(stage_q)));

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       grade,
    input  logic                             apply,
    input  logic [NUM_GRADES-1:0][CNT_W-1:0] eff_period,
    output logic                             tick,
    output logic                             cfg_err
);

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       gidx;
    logic [CNT_W-1:0] sel_p;
    logic             reload;

    // Code 3 falls back to the most demanding grade
    always_comb begin
        gidx  = (grade == 2'd3) ? 2'd2 : grade;
        sel_p = eff_period[gidx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TM_LOAD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        reload = 1'b0;
        unique case (st_q)
            TM_LOAD:  reload = 1'b1;
            TM_OFF:   reload = 1'b1;
            TM_COUNT: begin
                if (apply || (cnt_q == '0)) begin
                    reload = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default:  reload = 1'b1;
        endcase
        if (reload) begin
            if (sel_p == '0) begin
                st_d  = TM_OFF;
                cnt_d = '0;
            end else begin
                st_d  = TM_COUNT;
                cnt_d = sel_p - 1'b1;
            end
        end
    end

    always_comb begin
        tick    = (st_q == TM_COUNT) && (cnt_q == '0);
        cfg_err = (st_q == TM_OFF);
    end

    // R1: a running interval counts down one per cycle
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TM_COUNT && cnt_q != '0 && !apply) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R3: grade changes do not disturb a running interval
    p_grade_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TM_COUNT && cnt_q != '0 && !apply) |=> (st_q == TM_COUNT));
    // R9: reloading from a zero interval halts and flags the error
    p_zero_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && sel_p == '0) |=> (cfg_err && !tick));

endmodule

// File: rtl/rfsh_req_ctrl.sv
module rfsh_req_ctrl
    import rfsh_pkg::*;
#(
    parameter int unsigned ROWS     = 1024,
    parameter int unsigned PEND_MAX = 4,
    parameter int unsigned ROW_W    = $clog2(ROWS),
    parameter int unsigned PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ack,
    output logic              req,
    output logic [ROW_W-1:0]  row,
    output logic [PEND_W-1:0] pending
);

    localparam logic [PEND_W-1:0] CEIL    = PEND_W'(PEND_MAX);
    localparam logic [ROW_W-1:0]  LAST_RW = ROW_W'(ROWS - 1);

    req_state_e        rs_q, rs_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic [ROW_W-1:0]  row_q, row_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q   <= RQ_QUIET;
            pend_q <= '0;
            row_q  <= '0;
        end else begin
            rs_q   <= rs_d;
            pend_q <= pend_d;
            row_q  <= row_d;
        end
    end

    always_comb begin
        rs_d   = rs_q;
        pend_d = pend_q;
        row_d  = row_q;
        unique case (rs_q)
            RQ_QUIET: begin
                if (tick) begin
                    pend_d = PEND_W'(1);
                    rs_d   = RQ_ASK;
                end
            end
            RQ_ASK: begin
                if (ack) begin
                    row_d = (row_q == LAST_RW) ? '0 : row_q + 1'b1;
                end
                if (tick && !ack) begin
                    pend_d = (pend_q == CEIL) ? pend_q : pend_q + 1'b1;
                end else if (!tick && ack) begin
                    pend_d = pend_q - 1'b1;
                end
                rs_d = (pend_d == '0) ? RQ_QUIET : RQ_ASK;
            end
            default: begin
                rs_d   = RQ_QUIET;
                pend_d = '0;
            end
        endcase
    end

    always_comb begin
        req     = (rs_q == RQ_ASK);
        row     = row_q;
        pending = pend_q;
    end

    // R6: owed count never exceeds its ceiling, and a request is held until taken
    p_pend_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= CEIL);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    p_quiet_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q == RQ_QUIET) |-> (pend_q == '0));
    // R7: an accepted acknowledge moves the row forward by one with wrap
    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (row_q == (($past(row_q) == LAST_RW) ? '0 : $past(row_q) + 1'b1)));
    // R8: without a request the row stays put
    p_row_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(row_q));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned ROWS     = 1024,
    parameter int unsigned PEND_MAX = 4,
    parameter int unsigned DEF_P0   = 3200,
    parameter int unsigned DEF_P1   = 1600,
    parameter int unsigned DEF_P2   = 800,
    localparam int unsigned ROW_W   = $clog2(ROWS),
    localparam int unsigned PEND_W  = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic [1:0]        temp_grade,
    output logic              rfsh_req,
    input  logic              rfsh_ack,
    output logic [ROW_W-1:0]  rfsh_row,
    output logic [PEND_W-1:0] rfsh_pending,
    output logic              cfg_err
);

    logic                             apply;
    logic [NUM_GRADES-1:0][CNT_W-1:0] eff_period;
    logic                             tick;

    rfsh_cfg_regs #(
        .CNT_W  (CNT_W),
        .DEF_P0 (DEF_P0),
        .DEF_P1 (DEF_P1),
        .DEF_P2 (DEF_P2)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .apply      (apply),
        .eff_period (eff_period)
    );

    rfsh_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .grade      (temp_grade),
        .apply      (apply),
        .eff_period (eff_period),
        .tick       (tick),
        .cfg_err    (cfg_err)
    );

    rfsh_req_ctrl #(
        .ROWS     (ROWS),
        .PEND_MAX (PEND_MAX)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ack     (rfsh_ack),
        .req     (rfsh_req),
        .row     (rfsh_row),
        .pending (rfsh_pending)
    );

endmodule

// File: tb/rfsh_sched_tb.sv
`timescale 1ns/1ps
module rfsh_sched_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  temp_grade = '0;
    logic        rfsh_ack = 1'b0;
    logic        rfsh_req;
    logic [9:0]  rfsh_row;
    logic [2:0]  rfsh_pending;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rfsh_sched u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .temp_grade   (temp_grade),
        .rfsh_req     (rfsh_req),
        .rfsh_ack     (rfsh_ack),
        .rfsh_row     (rfsh_row),
        .rfsh_pending (rfsh_pending),
        .cfg_err      (cfg_err)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_wr    = 1'b1;
        cfg_addr  = 2'(a);
        cfg_wdata = 16'(d);
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic apply_cfg(input int p0, input int p1, input int p2);
        wr(0, 1);
        wr(1, p0);
        wr(2, p1);
        wr(3, p2);
        wr(0, 0);
    endtask

    // Row advances over a window of n cycles
    task automatic row_delta(input int n, output int d);
        int r0;
        r0 = int'(rfsh_row);
        repeat (n) step();
        d = (int'(rfsh_row) - r0 + 1024) % 1024;
    endtask

    task automatic wait_req(output int cycles);
        cycles = 0;
        while (!rfsh_req && cycles < 2000) begin
            step();
            cycles++;
        end
    endtask

    initial begin
        int d;
        int t;
        int prev;
        int jumps;
        bit wrapped;
        int hi;

        step();
        // R10: reset state
        chk(rfsh_req == 1'b0 && rfsh_pending == 0 && rfsh_row == 0 && cfg_err == 1'b0,
            "R10 reset outputs", int'(rfsh_req) + int'(rfsh_pending) + int'(rfsh_row) + int'(cfg_err), 0);
        rst_n = 1'b1;
        rfsh_ack = 1'b1;
        step();
        chk(cfg_err == 1'b0 && rfsh_req == 1'b0, "R10 after release", int'(cfg_err), 0);

        // R10/R1: default grade 0 interval of 3200 cycles
        repeat (10) step();
        row_delta(2 * 3200, d);
        chk(d == 2, "R10 default interval", d, 2);

        // R1/R2: sweep all grade codes over small intervals
        for (int g = 0; g < 4; g++) begin
            for (int p = 1; p <= 5; p++) begin
                int ge;
                ge = (g == 3) ? 2 : g;
                temp_grade = 2'(g);
                apply_cfg(ge == 0 ? p : p + 3, ge == 1 ? p : p + 3, ge == 2 ? p : p + 3);
                repeat (2 * (p + 3) + 6) step();
                row_delta(8 * p, d);
                chk(d == 8, $sformatf("R1 R2 grade %0d period %0d", g, p), d, 8);
            end
        end

        // R7: wrap from 1023 to 0 with interval 1
        temp_grade = 2'd0;
        apply_cfg(1, 1, 1);
        prev = int'(rfsh_row);
        jumps = 0;
        wrapped = 1'b0;
        for (int i = 0; i < 1100; i++) begin
            step();
            if (int'(rfsh_row) != prev && int'(rfsh_row) != (prev + 1) % 1024) jumps++;
            if (prev == 1023 && rfsh_row == 0) wrapped = 1'b1;
            prev = int'(rfsh_row);
        end
        chk(jumps == 0, "R7 row steps by one", jumps, 0);
        chk(wrapped, "R7 wrap 1023 to 0", int'(wrapped), 1);

        // R4/R5: staging held while busy
        apply_cfg(6, 6, 6);
        repeat (20) step();
        row_delta(48, d);
        chk(d == 8, "R5 base period 6", d, 8);
        wr(0, 1);
        wr(1, 3);
        repeat (10) step();
        row_delta(48, d);
        chk(d == 8, "R4 R5 old setting while busy", d, 8);
        wr(0, 0);
        repeat (10) step();
        row_delta(24, d);
        chk(d == 8, "R5 new period 3 after release", d, 8);
        wr(1, 5);
        wr(0, 0);
        repeat (10) step();
        row_delta(24, d);
        chk(d == 8, "R4 R5 no apply when flag clear", d, 8);
        wr(0, 1);
        wr(0, 0);
        repeat (14) step();
        row_delta(40, d);
        chk(d == 8, "R5 staged 5 applied", d, 8);

        // R3: grade sampled only at reload
        apply_cfg(30, 4, 4);
        rfsh_ack = 1'b0;
        repeat (3) step();
        while (rfsh_req) begin
            rfsh_ack = 1'b1;
            step();
            rfsh_ack = 1'b0;
        end
        wait_req(t);
        rfsh_ack = 1'b1;
        temp_grade = 2'd1;
        step();
        rfsh_ack = 1'b0;
        wait_req(t);
        chk(t + 1 == 30, "R3 running interval kept", t + 1, 30);
        rfsh_ack = 1'b1;
        step();
        rfsh_ack = 1'b0;
        wait_req(t);
        chk(t + 1 == 4, "R3 new grade next interval", t + 1, 4);

        // R6: pending count and saturation
        apply_cfg(3, 3, 3);
        rfsh_ack = 1'b1;
        while (rfsh_req) step();
        rfsh_ack = 1'b0;
        wait_req(t);
        chk(rfsh_pending == 1, "R6 first owed", int'(rfsh_pending), 1);
        for (int k = 2; k <= 6; k++) begin
            int ex;
            ex = (k > 4) ? 4 : k;
            repeat (3) step();
            chk(rfsh_pending == 3'(ex) && rfsh_req, "R6 owed count", int'(rfsh_pending), ex);
        end
        apply_cfg(200, 200, 200);
        chk(rfsh_pending == 4, "R6 saturated", int'(rfsh_pending), 4);
        prev = int'(rfsh_row);
        rfsh_ack = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            step();
            chk(rfsh_pending == 3'(4 - k) && int'(rfsh_row) == (prev + k) % 1024,
                "R6 R7 drain", int'(rfsh_pending), 4 - k);
        end
        chk(rfsh_req == 1'b0, "R6 request drops when drained", int'(rfsh_req), 0);

        // R8: acknowledge without request ignored
        prev = int'(rfsh_row);
        repeat (5) step();
        chk(int'(rfsh_row) == prev && rfsh_pending == 0, "R8 stray ack", int'(rfsh_row), prev);

        // R9: zero interval halts and flags
        temp_grade = 2'd0;
        apply_cfg(0, 7, 7);
        step();
        chk(cfg_err == 1'b1, "R9 error raised", int'(cfg_err), 1);
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (rfsh_req) hi++;
        end
        chk(hi == 0, "R9 no requests", hi, 0);
        temp_grade = 2'd1;
        step();
        chk(cfg_err == 1'b0, "R9 error clears", int'(cfg_err), 0);
        rfsh_ack = 1'b0;
        wait_req(t);
        chk(rfsh_req == 1'b1 && t <= 8, "R9 requests resume", t, 7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule